// File: doc/BRIEF.md
# Master Clock Divider and Continuity Tone Driver

This block sits on the crystal oscillator clock of a multimeter controller. It derives the internal master clock by dividing the oscillator clock by two. It also drives a piezo transducer with a square wave whose frequency is one sixtieth of the oscillator frequency, which gives 2 kHz from a 120 kHz crystal.

The tone is gated by the state of the meter. The sound decision is taken only when a conversion result is presented with its valid strobe. The tone sounds when three conditions hold: the meter is in low-resistance mode, the result was taken on the most sensitive resistance range, and the count is below the continuity limit. The default limit of 1000 counts is about 1 kΩ on the 4 kΩ full-scale range. When the tone is silent, the drive rests at the high rail.

Top module: `osc_div_beeper`

## Requirements
- R1: While rst_n is low, beep_drv is 1 and mclk is 0; the divider and tone counters restart from zero once reset is released.
- R2: mclk is a square wave with period MCLK_DIV oscillator cycles, high for MCLK_DIV/2 of them; by default it toggles every oscillator cycle.
- R3: While sounding, beep_drv is a 50% square wave with period 2*TONE_HALF*MCLK_DIV oscillator cycles. By default that is 60 cycles, 30 high and 30 low, which is 15 master clocks per half.
- R4: When the latched decision is silent, beep_drv stays at 1.
- R5: With low_ohm_mode at 0, beep_drv stays at 1 whatever reading is strobed.
- R6: The tone sounds only when rd_count < CONT_LIMIT. With the default limit, a strobed count of 999 sounds and 1000 is silent.
- R7: The tone sounds only when rd_range equals CONT_RANGE, with 0 meaning the most sensitive range. A low count on any other range is silent.
- R8: The sound decision changes only on a clock edge where rd_valid is 1. Changes to rd_count or rd_range without the strobe have no effect on beep_drv.
- R9: If low_ohm_mode falls while the tone sounds, beep_drv is 1 from the next clock edge onward.
- R10: Asserting reset while the tone sounds returns beep_drv to 1 and clears the sound decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_ohm_mode | input | 1 | 1 while the meter measures in low-resistance mode |
| rd_valid | input | 1 | One-cycle strobe marking a new latched reading |
| rd_count | input | CNT_W | Latched conversion count |
| rd_range | input | RANGE_W | Range of the latched reading, 0 = most sensitive |
| mclk | output | 1 | Internal master clock, oscillator divided by MCLK_DIV |
| beep_drv | output | 1 | Piezo drive level, 1 when idle |

## Verification
The bench builds the block with its default parameters. These are a divide-by-two master clock, a 15-master-clock half tone, a 12-bit count, a 2-bit range, continuity range 0 and a limit of 1000. A full tone period is then 60 oscillator cycles, so the bench can time exact high and low widths in a short run. It also places strobes on both sides of the 999/1000 boundary. Silencing on a mode change is timed from a moment when the tone is low, so a wrong gate cannot hide behind a high tone phase.

// File: rtl/beeper_pkg.sv
// Shared types for the divider and continuity tone block.
// Assumes: the tone drive idles at logic 1.
package beeper_pkg;
    typedef enum logic {
        TONE_SILENT = 1'b0,
        TONE_SOUND  = 1'b1
    } tone_dec_e;

    localparam logic DRIVE_IDLE = 1'b1;
endpackage

// File: rtl/mclk_divider.sv
// Divides the oscillator clock by DIV into the master clock and gives a
// one-cycle tick per master period.
// Assumes: DIV is even and at least 2; reset is synchronous, active low.
module mclk_divider #(
    parameter int DIV = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic mclk,
    output logic mtick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          mclk_q;

    // Next phase count, wrapping at DIV-1.
    always_comb begin
        cnt_nx = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end

    // Phase counter and registered master clock level.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            mclk_q <= (cnt_nx >= CW'(HALF));
        end
    end

    assign mclk  = mclk_q;
    assign mtick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/tone_square.sv
// Free-running square wave that flips every HALF_TICKS master ticks.
// Assumes: mtick is a one-cycle enable; the output starts high after reset.
module tone_square #(
    parameter int HALF_TICKS = 15
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic mtick,
    output logic tone
);
    import beeper_pkg::*;

    localparam int TW = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;

    logic [TW-1:0] tcnt_q;
    logic          tone_q;

    // Count master ticks and flip the tone level at each half period.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            tone_q <= DRIVE_IDLE;
        end else if (mtick) begin
            if (tcnt_q == TW'(HALF_TICKS - 1)) begin
                tcnt_q <= '0;
                tone_q <= ~tone_q;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    assign tone = tone_q;
endmodule

// File: rtl/cont_judge.sv
// Latches the continuity decision from a strobed reading.
// Assumes: rd_valid is a one-cycle strobe; range 0 is the most sensitive.
module cont_judge #(
    parameter int CNT_W      = 12,
    parameter int RANGE_W    = 2,
    parameter int CONT_RANGE = 0,
    parameter int CONT_LIMIT = 1000
) (
    input  logic                 osc_clk,
    input  logic                 rst_n,
    input  logic                 low_ohm_mode,
    input  logic                 rd_valid,
    input  logic [CNT_W-1:0]     rd_count,
    input  logic [RANGE_W-1:0]   rd_range,
    output beeper_pkg::tone_dec_e dec
);
    import beeper_pkg::*;

    logic      hit;
    tone_dec_e dec_q;

    // A reading counts as continuity when all three conditions hold.
    always_comb begin
        hit = low_ohm_mode
            && (rd_range == RANGE_W'(CONT_RANGE))
            && (rd_count <  CNT_W'(CONT_LIMIT));
    end

    // Update the decision only on a valid strobe.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            dec_q <= TONE_SILENT;
        end else if (rd_valid) begin
            dec_q <= hit ? TONE_SOUND : TONE_SILENT;
        end
    end

    assign dec = dec_q;
endmodule

// File: rtl/osc_div_beeper.sv
// Top: master clock divider plus gated continuity tone drive.
// Assumes: one oscillator clock domain; synchronous active-low reset;
// the drive idles high and is registered so it never glitches.
module osc_div_beeper #(
    parameter int MCLK_DIV   = 2,
    parameter int TONE_HALF  = 15,
    parameter int CNT_W      = 12,
    parameter int RANGE_W    = 2,
    parameter int CONT_RANGE = 0,
    parameter int CONT_LIMIT = 1000
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               low_ohm_mode,
    input  logic               rd_valid,
    input  logic [CNT_W-1:0]   rd_count,
    input  logic [RANGE_W-1:0] rd_range,
    output logic               mclk,
    output logic               beep_drv
);
    import beeper_pkg::*;

    logic      mtick;
    logic      tone;
    tone_dec_e dec;
    logic      drv_q;

    mclk_divider #(
        .DIV (MCLK_DIV)
    ) u_div (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .mclk    (mclk),
        .mtick   (mtick)
    );

    tone_square #(
        .HALF_TICKS (TONE_HALF)
    ) u_tone (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .mtick   (mtick),
        .tone    (tone)
    );

    cont_judge #(
        .CNT_W      (CNT_W),
        .RANGE_W    (RANGE_W),
        .CONT_RANGE (CONT_RANGE),
        .CONT_LIMIT (CONT_LIMIT)
    ) u_judge (
        .osc_clk      (osc_clk),
        .rst_n        (rst_n),
        .low_ohm_mode (low_ohm_mode),
        .rd_valid     (rd_valid),
        .rd_count     (rd_count),
        .rd_range     (rd_range),
        .dec          (dec)
    );

    // Registered drive: pass the tone only when sounding and in low-ohm mode.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            drv_q <= DRIVE_IDLE;
        end else begin
            drv_q <= ((dec == TONE_SOUND) && low_ohm_mode) ? tone : DRIVE_IDLE;
        end
    end

    assign beep_drv = drv_q;
endmodule

// File: rtl/osc_div_beeper_chk.sv
// Checker for osc_div_beeper, attached with bind. Watches ports only.
// Assumes: default-style parameters small enough for run counters of 16 bits.
module osc_div_beeper_chk #(
    parameter int MCLK_DIV  = 2,
    parameter int TONE_HALF = 15
) (
    input logic osc_clk,
    input logic rst_n,
    input logic low_ohm_mode,
    input logic mclk,
    input logic beep_drv
);
    localparam int HI_MAX  = MCLK_DIV / 2;
    localparam int LOW_MAX = TONE_HALF * MCLK_DIV;

    logic [15:0] hi_run;
    logic [15:0] low_run;

    // Track consecutive high samples of mclk and low samples of the drive.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            low_run <= '0;
        end else begin
            hi_run  <= mclk      ? hi_run + 1'b1  : '0;
            low_run <= !beep_drv ? low_run + 1'b1 : '0;
        end
    end

    AST_MCLK_HIGH_WIDTH: assert property (@(posedge osc_clk) disable iff (!rst_n)
        mclk |-> (hi_run < 16'(HI_MAX))); // R2

    AST_TONE_LOW_WIDTH: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !beep_drv |-> (low_run < 16'(LOW_MAX))); // R3

    AST_IDLE_WHEN_MODE_OFF: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !low_ohm_mode |=> beep_drv); // R5

    AST_LOW_NEEDS_MODE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(beep_drv) |-> $past(low_ohm_mode)); // R9
endmodule

bind osc_div_beeper osc_div_beeper_chk #(
    .MCLK_DIV  (MCLK_DIV),
    .TONE_HALF (TONE_HALF)
) u_chk (
    .osc_clk      (osc_clk),
    .rst_n        (rst_n),
    .low_ohm_mode (low_ohm_mode),
    .mclk         (mclk),
    .beep_drv     (beep_drv)
);

// File: tb/test_osc_div_beeper.sv
`timescale 1ns/1ps
module test_osc_div_beeper;
    localparam int DIV     = 2;
    localparam int HALF    = 15;
    localparam int HALF_OSC = HALF * DIV;

    logic        osc_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        low_ohm_mode = 1'b0;
    logic        rd_valid = 1'b0;
    logic [11:0] rd_count = '0;
    logic [1:0]  rd_range = '0;
    logic        mclk;
    logic        beep_drv;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 osc_clk = ~osc_clk;

    osc_div_beeper i_osc_div_beeper (
        .osc_clk      (osc_clk),
        .rst_n        (rst_n),
        .low_ohm_mode (low_ohm_mode),
        .rd_valid     (rd_valid),
        .rd_count     (rd_count),
        .rd_range     (rd_range),
        .mclk         (mclk),
        .beep_drv     (beep_drv)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input bit mode, input int cnt, input int rng);
        low_ohm_mode = mode;
        rd_count = 12'(cnt);
        rd_range = 2'(rng);
        rd_valid = 1'b1;
        @(negedge osc_clk);
        rd_valid = 1'b0;
        repeat (2) @(negedge osc_clk);
    endtask

    // Number of low samples of beep_drv over n cycles.
    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge osc_clk);
            if (!beep_drv) lows++;
        end
    endtask

    // Wait for a high-to-low transition of beep_drv, up to max cycles.
    task automatic wait_fall(input int max, output bit found);
        bit prev = beep_drv;
        found = 0;
        for (int i = 0; i < max && !found; i++) begin
            @(negedge osc_clk);
            if (prev && !beep_drv) found = 1;
            prev = beep_drv;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        check(beep_drv == 1'b1, "R1 drive idle in reset", beep_drv, 1);
        check(mclk == 1'b0, "R1 mclk low in reset", mclk, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_mclk();
        int toggles = 0;
        bit prev;
        @(negedge osc_clk);
        prev = mclk;
        for (int i = 0; i < 20; i++) begin
            @(negedge osc_clk);
            if (mclk != prev) toggles++;
            prev = mclk;
        end
        check(toggles == 20, "R2 mclk toggles every cycle", toggles, 20);
    endtask

    task automatic t_tone_shape();
        bit found;
        int lo = 0;
        int hi = 0;
        strobe(1'b1, 500, 0);
        wait_fall(200, found);
        check(found, "R3 tone starts", found, 1);
        lo = 1;
        while (lo < 200) begin
            @(negedge osc_clk);
            if (beep_drv) break;
            lo++;
        end
        hi = 1;
        while (hi < 200) begin
            @(negedge osc_clk);
            if (!beep_drv) break;
            hi++;
        end
        check(lo == HALF_OSC, "R3 low half width", lo, HALF_OSC);
        check(hi == HALF_OSC, "R3 high half width", hi, HALF_OSC);
    endtask

    task automatic t_threshold();
        int lows;
        strobe(1'b1, 1000, 0);
        count_low(150, lows);
        check(lows == 0, "R6 count 1000 silent", lows, 0);
        check(lows == 0, "R4 idle level high", lows, 0);
        strobe(1'b1, 999, 0);
        count_low(150, lows);
        check(lows > 0, "R6 count 999 sounds", lows, 1);
    endtask

    task automatic t_range();
        int lows;
        strobe(1'b1, 10, 1);
        count_low(150, lows);
        check(lows == 0, "R7 other range silent", lows, 0);
        strobe(1'b1, 10, 3);
        count_low(150, lows);
        check(lows == 0, "R7 top range silent", lows, 0);
    endtask

    task automatic t_mode_off();
        int lows;
        strobe(1'b0, 10, 0);
        count_low(150, lows);
        check(lows == 0, "R5 mode off silent", lows, 0);
    endtask

    task automatic t_hold();
        int lows;
        strobe(1'b1, 10, 0);
        rd_count = 12'd3000;
        rd_range = 2'd2;
        count_low(150, lows);
        check(lows > 0, "R8 no strobe keeps sound", lows, 1);
        strobe(1'b1, 3000, 0);
        rd_count = 12'd5;
        rd_range = 2'd0;
        count_low(150, lows);
        check(lows == 0, "R8 no strobe keeps silence", lows, 0);
    endtask

    task automatic t_mode_drop();
        bit found;
        int lows;
        strobe(1'b1, 20, 0);
        wait_fall(200, found);
        check(!beep_drv, "R9 tone low before drop", beep_drv, 0);
        low_ohm_mode = 1'b0;
        @(negedge osc_clk);
        check(beep_drv == 1'b1, "R9 silent next edge", beep_drv, 1);
        count_low(100, lows);
        check(lows == 0, "R9 stays silent", lows, 0);
    endtask

    task automatic t_reset_mid();
        bit found;
        int lows;
        strobe(1'b1, 20, 0);
        wait_fall(200, found);
        rst_n = 1'b0;
        @(negedge osc_clk);
        check(beep_drv == 1'b1, "R10 reset forces idle", beep_drv, 1);
        rst_n = 1'b1;
        count_low(150, lows);
        check(lows == 0, "R10 decision cleared", lows, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge osc_clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mclk();
        t_tone_shape();
        t_threshold();
        t_range();
        t_mode_off();
        t_hold();
        t_mode_drop();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule